// File: doc/BRIEF.md
# Descriptor-Driven Memory Transfer Controller

This block moves data between memory locations under the control of transfer descriptors that themselves live in memory. A start pulse carries the byte address of a descriptor. The controller reads the four descriptor words and performs the unit copies they call for. It then writes the updated addresses and counter back into the same descriptor. Because all channel state lives in memory, any number of logical channels can share one controller. Software prepares one descriptor per channel and starts the controller with that channel's descriptor address.

Each descriptor selects one of three modes: normal, repeat or block. It also sets a unit size of 1, 2 or 4 bytes, and chooses for each side whether the address increments, decrements or stays fixed. A descriptor may chain to the next descriptor, which sits 16 bytes further on. The chain can be unconditional, or it can be taken only when the counter has just reached zero. A one-cycle `done` pulse marks the end of the last write-back of a chain.

The memory side is a request/response master port. A request is offered with `mem_req_valid` and is taken in a cycle where `mem_req_ready` is also high. While it waits for ready, the controller holds the address, direction, size and write data steady. A read is answered by a one-cycle `mem_rsp_valid` in any later cycle. The controller keeps at most one read outstanding and issues nothing else until that read is answered, so it never back-pressures a response. Unit data travels right-aligned in the 32-bit data buses.

Top module: `desc_xfer_ctrl`

## Requirements
- R1: A `act_start` pulse while idle reads four 32-bit descriptor words at base, base+4, base+8 and base+12: control, source address, destination address, count word. A pulse while a transfer or chain is in progress is ignored and starts nothing.
- R2: Control word fields: [1:0] unit size, [3:2] source stepping, [5:4] destination stepping, [7:6] mode (0 normal, 1 repeat, 2 block), [8] area side (1 = source, 0 = destination), [9] chain enable, [10] chain only on zero.
- R3: Unit size code 0, 1, 2 moves 1, 2 or 4 bytes per unit. The code is driven on `mem_req_size` for data reads and writes, and descriptor accesses always use code 2.
- R4: After each unit, each address independently steps by the unit byte count. Stepping code 1 increments, code 2 decrements, and code 0 leaves the address fixed.
- R5: In normal mode each activation moves one unit and decrements count word bits [15:0] by one. A count of 0 stands for 65536 and is written back as 0xFFFF.
- R6: In repeat mode, count bits [7:0] hold the remaining units and bits [15:8] the reload value; 0 in either stands for 256. Each activation moves one unit. When the remaining count was 1, it is reloaded and the area-side address is wound back by reload × unit bytes.
- R7: In block mode each activation moves count bits [23:16] units (0 stands for 256) and then decrements bits [15:0]. The area-side address returns to its fetched value, and the other side keeps its advance.
- R8: After the data moves, the updated source address, destination address and count word are written back to base+4, base+8 and base+12. Bits [31:24] of the count word are preserved.
- R9: With chain enable set and chain-on-zero clear, the descriptor at base+16 is fetched and run in the same activation.
- R10: With chain enable and chain-on-zero both set, chaining happens only when the counter has just reached zero in this activation. In repeat mode that is the reload event.
- R11: `done` is high for exactly one cycle after the final write-back of an activation. No memory request is made while the controller is idle.
- R12: A request held without `mem_req_ready` stays unchanged into the next cycle, and no request is issued while a read is awaiting its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| act_start | input | 1 | One-cycle activation request |
| act_base | input | AW | Byte address of the first descriptor, sampled with `act_start` |
| done | output | 1 | One-cycle pulse at the end of an activation |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the offered request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address of the access |
| mem_req_size | output | 2 | Access size code (0 byte, 1 two bytes, 2 four bytes) |
| mem_req_wdata | output | 32 | Write data, right-aligned |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 32 | Read data, right-aligned |

## Verification
Normal mode is swept over every combination of unit size and source and destination stepping. This separates each byte count from each stepping direction, both in the copied bytes and in the written-back addresses. Repeat and block runs are tried with the area on either side and with increment and decrement stepping, over several activations. They show whether the wind-back lands exactly on the start and whether the opposite side keeps its advance. Zero-encoded counts and block sizes, unconditional chaining, and chain-on-zero with both a non-zero and a zero outcome are each tried against an arithmetic memory model. A second activation is also pulsed while the controller is busy, to show that it leaves its own descriptor untouched. The memory accepts requests on an irregular pseudo-random pattern throughout, so every result is also obtained under back-pressure.

// File: rtl/dx_pkg.sv
package dx_pkg;

  localparam int WORD_W     = 32;
  localparam int DESC_BYTES = 16;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_FULL = 2'd2} unit_sz_e;
  typedef enum logic [1:0] {AM_HOLD = 2'd0, AM_UP = 2'd1, AM_DOWN = 2'd2} addr_mode_e;
  typedef enum logic [1:0] {XM_NORMAL = 2'd0, XM_REPEAT = 2'd1, XM_BLOCK = 2'd2} xfer_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_FWAIT, ST_RD, ST_RWAIT, ST_WR,
    ST_STEP, ST_FIN, ST_WB, ST_NEXT, ST_DONE
  } st_e;

  typedef struct packed {
    logic       chain_zero;
    logic       chain_en;
    logic       area_src;
    logic [1:0] xmode;
    logic [1:0] dmode;
    logic [1:0] smode;
    logic [1:0] usz;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [10:0] w);
    ctrl_t c;
    c.usz        = w[1:0];
    c.smode      = w[3:2];
    c.dmode      = w[5:4];
    c.xmode      = w[7:6];
    c.area_src   = w[8];
    c.chain_en   = w[9];
    c.chain_zero = w[10];
    return c;
  endfunction

  function automatic logic [8:0] units_of(input logic [7:0] v);
    return (v == 8'd0) ? 9'd256 : {1'b0, v};
  endfunction

  function automatic logic [WORD_W-1:0] fit_unit(input logic [WORD_W-1:0] v, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return {24'd0, v[7:0]};
      SZ_HALF: return {16'd0, v[15:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/dx_addr_unit.sv
module dx_addr_unit
  import dx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          rewind,
  input  logic [8:0]    rewind_units,
  input  logic [1:0]    mode,
  input  logic [1:0]    usz,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] unit_bytes;
  logic [AW-1:0] back_off;

  assign unit_bytes = AW'(1) << usz;
  assign back_off   = AW'(rewind_units) << usz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (step) begin
      if (mode == AM_UP)        addr <= addr + unit_bytes;
      else if (mode == AM_DOWN) addr <= addr - unit_bytes;
    end else if (rewind) begin
      if (mode == AM_UP)        addr <= addr - back_off;
      else if (mode == AM_DOWN) addr <= addr + back_off;
    end
  end

endmodule

// File: rtl/dx_count_unit.sv
module dx_count_unit
  import dx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              is_repeat,
  input  logic              dec,
  output logic [WORD_W-1:0] word,
  output logic              hit_zero,
  output logic              wrap_next,
  output logic [8:0]        blk_units,
  output logic [8:0]        rld_units
);

  logic [7:0]  top8;
  logic [7:0]  bsz8;
  logic [15:0] cnt16;

  assign word      = {top8, bsz8, cnt16};
  assign wrap_next = (cnt16[7:0] == 8'd1);
  assign blk_units = units_of(bsz8);
  assign rld_units = units_of(cnt16[15:8]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top8     <= '0;
      bsz8     <= '0;
      cnt16    <= '0;
      hit_zero <= 1'b0;
    end else if (load) begin
      top8     <= load_word[31:24];
      bsz8     <= load_word[23:16];
      cnt16    <= load_word[15:0];
      hit_zero <= 1'b0;
    end else if (dec) begin
      if (is_repeat) begin
        if (wrap_next) begin
          cnt16[7:0] <= cnt16[15:8];
          hit_zero   <= 1'b1;
        end else begin
          cnt16[7:0] <= cnt16[7:0] - 8'd1;
          hit_zero   <= 1'b0;
        end
      end else begin
        cnt16    <= cnt16 - 16'd1;
        hit_zero <= (cnt16 == 16'd1);
      end
    end
  end

endmodule

// File: rtl/desc_xfer_ctrl.sv
module desc_xfer_ctrl
  import dx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_start,
  input  logic [AW-1:0]     act_base,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [AW-1:0]     mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);

  localparam int NSIDE = 2;

  st_e               st;
  logic [AW-1:0]     base;
  logic [1:0]        widx;
  ctrl_t             cfg;
  logic [WORD_W-1:0] dbuf;
  logic [8:0]        left;

  logic              rsp_take;
  logic              area_hit;
  logic [8:0]        rw_units;
  logic [NSIDE-1:0]  ld_a, stp_a, rw_a;
  logic [1:0]        mode_a [NSIDE];
  logic [AW-1:0]     addr_a [NSIDE];

  logic              cnt_ld, cnt_dec, cnt_zero, cnt_wrap;
  logic [WORD_W-1:0] cnt_word;
  logic [8:0]        cnt_bunits, cnt_runits;

  logic [AW-1:0]     desc_addr;
  logic [WORD_W-1:0] wb_word;
  logic              take_chain;

  assign rsp_take  = (st == ST_FWAIT) && mem_rsp_valid;
  assign cnt_ld    = rsp_take && (widx == 2'd3);
  assign cnt_dec   = (st == ST_FIN);
  assign area_hit  = (st == ST_FIN) &&
                     ((cfg.xmode == XM_BLOCK) || ((cfg.xmode == XM_REPEAT) && cnt_wrap));
  assign rw_units  = (cfg.xmode == XM_BLOCK) ? cnt_bunits : cnt_runits;
  assign desc_addr = base + AW'({widx, 2'b00});
  assign take_chain = cfg.chain_en && (!cfg.chain_zero || cnt_zero);

  always_comb begin
    ld_a[0]   = rsp_take && (widx == 2'd1);
    ld_a[1]   = rsp_take && (widx == 2'd2);
    stp_a     = {NSIDE{st == ST_STEP}};
    rw_a[0]   = area_hit && cfg.area_src;
    rw_a[1]   = area_hit && !cfg.area_src;
    mode_a[0] = cfg.smode;
    mode_a[1] = cfg.dmode;
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dx_addr_unit #(.AW(AW)) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (ld_a[g]),
      .load_val     (mem_rsp_data[AW-1:0]),
      .step         (stp_a[g]),
      .rewind       (rw_a[g]),
      .rewind_units (rw_units),
      .mode         (mode_a[g]),
      .usz          (cfg.usz),
      .addr         (addr_a[g])
    );
  end

  dx_count_unit u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cnt_ld),
    .load_word (mem_rsp_data),
    .is_repeat (cfg.xmode == XM_REPEAT),
    .dec       (cnt_dec),
    .word      (cnt_word),
    .hit_zero  (cnt_zero),
    .wrap_next (cnt_wrap),
    .blk_units (cnt_bunits),
    .rld_units (cnt_runits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      base <= '0;
      widx <= '0;
      cfg  <= '0;
      dbuf <= '0;
      left <= '0;
    end else begin
      case (st)
        ST_IDLE: if (act_start) begin
          base <= act_base;
          widx <= 2'd0;
          st   <= ST_FETCH;
        end
        ST_FETCH: if (mem_req_ready) st <= ST_FWAIT;
        ST_FWAIT: if (mem_rsp_valid) begin
          if (widx == 2'd0) cfg <= decode_ctrl(mem_rsp_data[10:0]);
          if (widx == 2'd3) begin
            left <= (cfg.xmode == XM_BLOCK) ? units_of(mem_rsp_data[23:16]) : 9'd1;
            st   <= ST_RD;
          end else begin
            widx <= widx + 2'd1;
            st   <= ST_FETCH;
          end
        end
        ST_RD: if (mem_req_ready) st <= ST_RWAIT;
        ST_RWAIT: if (mem_rsp_valid) begin
          dbuf <= fit_unit(mem_rsp_data, cfg.usz);
          st   <= ST_WR;
        end
        ST_WR: if (mem_req_ready) st <= ST_STEP;
        ST_STEP: begin
          left <= left - 9'd1;
          st   <= (left == 9'd1) ? ST_FIN : ST_RD;
        end
        ST_FIN: begin
          widx <= 2'd1;
          st   <= ST_WB;
        end
        ST_WB: if (mem_req_ready) begin
          if (widx == 2'd3) st <= ST_NEXT;
          else              widx <= widx + 2'd1;
        end
        ST_NEXT: begin
          if (take_chain) begin
            base <= base + AW'(DESC_BYTES);
            widx <= 2'd0;
            st   <= ST_FETCH;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wb_word = '0;
    case (widx)
      2'd1:    wb_word[AW-1:0] = addr_a[0];
      2'd2:    wb_word[AW-1:0] = addr_a[1];
      2'd3:    wb_word = cnt_word;
      default: wb_word = '0;
    endcase
  end

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_size  = SZ_FULL;
    mem_req_wdata = '0;
    case (st)
      ST_FETCH: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_addr;
      end
      ST_RD: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = addr_a[0];
        mem_req_size  = cfg.usz;
      end
      ST_WR: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = addr_a[1];
        mem_req_size  = cfg.usz;
        mem_req_wdata = dbuf;
      end
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = desc_addr;
        mem_req_wdata = wb_word;
      end
      default: ;
    endcase
  end

  assign done = (st == ST_DONE);

endmodule

// File: rtl/dx_checker.sv
module dx_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act_start,
  input logic          done,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [1:0]    mem_req_size,
  input logic [31:0]   mem_req_wdata,
  input logic          mem_rsp_valid
);

  logic busy_q;
  logic rd_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_pend <= 1'b0;
    end else begin
      if (done)           busy_q <= 1'b0;
      else if (act_start) busy_q <= 1'b1;
      if (mem_rsp_valid)  rd_pend <= 1'b0;
      else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pend <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
    $stable(mem_req_write) && $stable(mem_req_size) && $stable(mem_req_wdata)); // R12
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_req_valid); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mem_req_valid); // R11
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_q); // R11
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_size != 2'd3); // R3

endmodule

bind desc_xfer_ctrl dx_checker #(.AW(AW)) u_dx_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .act_start     (act_start),
  .done          (done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_size  (mem_req_size),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/desc_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module desc_xfer_ctrl_bench;

  localparam int MEMB = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_start = 1'b0;
  logic [31:0] act_base = '0;
  logic        done;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [15:0] lf = 16'hACE1;

  logic [7:0] mem [MEMB];
  logic [7:0] em  [MEMB];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  desc_xfer_ctrl u_desc_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .act_start(act_start), .act_base(act_base), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  assign mem_req_ready = lf[0] | lf[3];

  always @(posedge clk) begin : mem_model
    logic [31:0] t;
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        for (int k = 0; k < (1 << mem_req_size); k++)
          mem[(mem_req_addr + k) % MEMB] <= mem_req_wdata[8*k +: 8];
      end else begin
        t = '0;
        for (int k = 0; k < (1 << mem_req_size); k++)
          t[8*k +: 8] = mem[(mem_req_addr + k) % MEMB];
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= t;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  function automatic logic [31:0] em32(input int a);
    return {em[(a+3)%MEMB], em[(a+2)%MEMB], em[(a+1)%MEMB], em[a%MEMB]};
  endfunction

  task automatic put32(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) begin
      mem[a+k] <= v[8*k +: 8];
      em[a+k]  = v[8*k +: 8];
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < MEMB; i++) begin
      mem[i] <= 8'(i * 13 + seed * 7 + (i >> 8));
      em[i]  = 8'(i * 13 + seed * 7 + (i >> 8));
    end
  endtask

  function automatic logic [31:0] ctrl(input int sz, input int sm, input int dm, input int xm,
                                       input int side, input int ce, input int cz);
    return 32'(sz | (sm << 2) | (dm << 4) | (xm << 6) | (side << 8) | (ce << 9) | (cz << 10));
  endfunction

  function automatic logic [31:0] adv(input logic [31:0] a, input logic [1:0] m, input int amt);
    if (m == 2'd1) return a + 32'(amt);
    if (m == 2'd2) return a - 32'(amt);
    return a;
  endfunction

  // arithmetic model of one activation, built from the requirements
  task automatic model(input int base0);
    int b;
    bit go;
    b = base0;
    go = 1'b1;
    while (go) begin
      logic [31:0] c, s, d, n, s0, d0;
      int nb, units, ru;
      bit z;
      c = em32(b); s = em32(b + 4); d = em32(b + 8); n = em32(b + 12);
      s0 = s; d0 = d;
      nb = 1 << c[1:0];
      units = (c[7:6] == 2'd2) ? ((n[23:16] == 8'd0) ? 256 : int'(n[23:16])) : 1;
      for (int u = 0; u < units; u++) begin
        for (int k = 0; k < nb; k++) em[(d + k) % MEMB] = em[(s + k) % MEMB];
        s = adv(s, c[3:2], nb);
        d = adv(d, c[5:4], nb);
      end
      z = 1'b0;
      if (c[7:6] == 2'd1) begin
        if (n[7:0] == 8'd1) begin
          ru = (n[15:8] == 8'd0) ? 256 : int'(n[15:8]);
          n[7:0] = n[15:8];
          z = 1'b1;
          if (c[8]) s = adv(s, c[3:2], -ru * nb);
          else      d = adv(d, c[5:4], -ru * nb);
        end else begin
          n[7:0] = n[7:0] - 8'd1;
        end
      end else begin
        n[15:0] = n[15:0] - 16'd1;
        z = (n[15:0] == 16'd0);
        if (c[7:6] == 2'd2) begin
          if (c[8]) s = s0;
          else      d = d0;
        end
      end
      for (int k = 0; k < 4; k++) begin
        em[b + 4 + k]  = s[8*k +: 8];
        em[b + 8 + k]  = d[8*k +: 8];
        em[b + 12 + k] = n[8*k +: 8];
      end
      if (c[9] && (!c[10] || z)) b = b + 16;
      else go = 1'b0;
    end
  endtask

  task automatic cmp_mem(input string req, input string what);
    int bad;
    int first;
    bad = 0;
    first = 0;
    for (int i = 0; i < MEMB; i++)
      if (mem[i] !== em[i]) begin
        if (bad == 0) first = i;
        bad++;
      end
    chk(bad == 0, req, $sformatf("%s mem@%0h", what, first), mem[first], em[first]);
  endtask

  task automatic activate(input int base, input string req);
    int t;
    t = 0;
    @(negedge clk);
    act_start = 1'b1;
    act_base  = 32'(base);
    @(negedge clk);
    act_start = 1'b0;
    while (done !== 1'b1 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done === 1'b1, req, "done reached", done, 1);
    model(base);
    @(negedge clk);
    chk(done === 1'b0, "R11", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, "R11", "reset done", done, 0);
    chk(mem_req_valid === 1'b0, "R11", "reset no request", mem_req_valid, 0);

    // normal mode sweep over size and both stepping codes
    for (int sz = 0; sz < 3; sz++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++) begin
          int nb;
          nb = 1 << sz;
          fill(sz * 9 + sm * 3 + dm);
          put32(32'h40, ctrl(sz, sm, dm, 0, 0, 0, 0));
          put32(32'h44, 32'h500);
          put32(32'h48, 32'h900);
          put32(32'h4C, 32'h00AB0003);
          activate(32'h40, "R1");
          cmp_mem("R2", "normal sweep");
          chk(mem32(32'h44) == adv(32'h500, 2'(sm), nb), "R4", "src step", mem32(32'h44), adv(32'h500, 2'(sm), nb));
          chk(mem32(32'h48) == adv(32'h900, 2'(dm), nb), "R8", "dst write-back", mem32(32'h48), adv(32'h900, 2'(dm), nb));
          chk(mem32(32'h4C) == 32'h00AB0002, "R5", "count dec", mem32(32'h4C), 32'h00AB0002);
          chk(mem[32'h900] == em[32'h900] && mem[32'h900 + nb - 1] == em[32'h500 + nb - 1], "R3",
              "unit bytes", mem[32'h900 + nb - 1], em[32'h500 + nb - 1]);
        end

    // normal count zero means 65536
    fill(40);
    put32(32'h40, ctrl(2, 1, 1, 0, 0, 0, 0));
    put32(32'h44, 32'h500); put32(32'h48, 32'h900); put32(32'h4C, 32'h12340000);
    activate(32'h40, "R5");
    chk(mem32(32'h4C) == 32'h1234FFFF, "R5", "zero count", mem32(32'h4C), 32'h1234FFFF);
    cmp_mem("R5", "zero count mem");

    // repeat mode, destination area
    fill(41);
    put32(32'h40, ctrl(1, 1, 1, 1, 0, 0, 0));
    put32(32'h44, 32'h500); put32(32'h48, 32'h900); put32(32'h4C, 32'h00000303);
    for (int a = 0; a < 4; a++) begin
      activate(32'h40, "R6");
      cmp_mem("R6", "repeat dst mem");
      if (a == 2) begin
        chk(mem32(32'h48) == 32'h900, "R6", "dst rewound", mem32(32'h48), 32'h900);
        chk(mem32(32'h4C) == 32'h0303, "R6", "count reloaded", mem32(32'h4C), 32'h0303);
        chk(mem32(32'h44) == 32'h506, "R6", "src keeps going", mem32(32'h44), 32'h506);
      end
    end
    chk(mem32(32'h48) == 32'h902, "R6", "dst after wrap", mem32(32'h48), 32'h902);

    // repeat mode, source area stepping down
    fill(42);
    put32(32'h40, ctrl(2, 2, 1, 1, 1, 0, 0));
    put32(32'h44, 32'h600); put32(32'h48, 32'h900); put32(32'h4C, 32'h00000202);
    activate(32'h40, "R6");
    activate(32'h40, "R6");
    chk(mem32(32'h44) == 32'h600, "R6", "src rewound", mem32(32'h44), 32'h600);
    chk(mem32(32'h48) == 32'h908, "R6", "dst advanced", mem32(32'h48), 32'h908);
    cmp_mem("R6", "repeat src mem");

    // repeat reload of zero means 256
    fill(43);
    put32(32'h40, ctrl(0, 1, 1, 1, 0, 0, 0));
    put32(32'h44, 32'h500); put32(32'h48, 32'h900); put32(32'h4C, 32'h00000001);
    activate(32'h40, "R6");
    chk(mem32(32'h48) == 32'h801, "R6", "rewind 256", mem32(32'h48), 32'h801);
    chk(mem32(32'h4C) == 32'h0, "R6", "reload zero", mem32(32'h4C), 32'h0);

    // block mode over sizes, destination area
    for (int sz = 0; sz < 3; sz++) begin
      fill(50 + sz);
      put32(32'h40, ctrl(sz, 1, 1, 2, 0, 0, 0));
      put32(32'h44, 32'h500); put32(32'h48, 32'h900); put32(32'h4C, 32'h00050002);
      for (int k = 1; k <= 2; k++) begin
        activate(32'h40, "R7");
        cmp_mem("R12", "block mem under back-pressure");
        chk(mem32(32'h48) == 32'h900, "R7", "block dst restored", mem32(32'h48), 32'h900);
        chk(mem32(32'h44) == 32'h500 + 32'(5 * k * (1 << sz)), "R7", "block src advance",
            mem32(32'h44), 32'h500 + 32'(5 * k * (1 << sz)));
      end
      chk(mem32(32'h4C) == 32'h00050000, "R7", "block count", mem32(32'h4C), 32'h00050000);
    end

    // block mode, source area stepping down
    fill(55);
    put32(32'h40, ctrl(1, 2, 1, 2, 1, 0, 0));
    put32(32'h44, 32'h700); put32(32'h48, 32'h900); put32(32'h4C, 32'h00030001);
    activate(32'h40, "R7");
    chk(mem32(32'h44) == 32'h700, "R7", "src area restored", mem32(32'h44), 32'h700);
    chk(mem32(32'h48) == 32'h906, "R7", "dst advanced", mem32(32'h48), 32'h906);
    cmp_mem("R7", "block src mem");

    // block size zero means 256 units
    fill(56);
    put32(32'h40, ctrl(0, 1, 1, 2, 0, 0, 0));
    put32(32'h44, 32'h500); put32(32'h48, 32'h900); put32(32'h4C, 32'h00000001);
    activate(32'h40, "R7");
    chk(mem32(32'h44) == 32'h600, "R7", "block 256", mem32(32'h44), 32'h600);
    cmp_mem("R7", "block 256 mem");

    // unconditional chain
    fill(60);
    put32(32'h80, ctrl(2, 1, 1, 0, 0, 1, 0));
    put32(32'h84, 32'h500); put32(32'h88, 32'h900); put32(32'h8C, 32'h5);
    put32(32'h90, ctrl(0, 1, 1, 0, 0, 0, 0));
    put32(32'h94, 32'h600); put32(32'h98, 32'hA00); put32(32'h9C, 32'h1);
    activate(32'h80, "R9");
    chk(mem32(32'h98) == 32'hA01, "R9", "second ran", mem32(32'h98), 32'hA01);
    chk(mem32(32'h9C) == 32'h0, "R9", "second count", mem32(32'h9C), 32'h0);
    cmp_mem("R9", "chain mem");

    // chain only on zero
    fill(61);
    put32(32'h80, ctrl(2, 1, 1, 0, 0, 1, 1));
    put32(32'h84, 32'h500); put32(32'h88, 32'h900); put32(32'h8C, 32'h2);
    put32(32'h90, ctrl(0, 1, 1, 0, 0, 0, 0));
    put32(32'h94, 32'h600); put32(32'h98, 32'hA00); put32(32'h9C, 32'h3);
    activate(32'h80, "R10");
    chk(mem32(32'h98) == 32'hA00, "R10", "no chain non-zero", mem32(32'h98), 32'hA00);
    cmp_mem("R10", "no chain mem");
    activate(32'h80, "R10");
    chk(mem32(32'h98) == 32'hA01, "R10", "chain on zero", mem32(32'h98), 32'hA01);
    cmp_mem("R10", "zero chain mem");

    // start pulse while busy is ignored
    fill(70);
    put32(32'h40, ctrl(2, 1, 1, 2, 0, 0, 0));
    put32(32'h44, 32'h500); put32(32'h48, 32'h900); put32(32'h4C, 32'h00280001);
    put32(32'hC0, ctrl(0, 1, 1, 0, 0, 0, 0));
    put32(32'hC4, 32'h600); put32(32'hC8, 32'hB00); put32(32'hCC, 32'h1);
    begin
      int t;
      int extra;
      t = 0;
      extra = 0;
      @(negedge clk); act_start = 1'b1; act_base = 32'h40;
      @(negedge clk); act_start = 1'b0;
      repeat (10) @(negedge clk);
      act_start = 1'b1; act_base = 32'hC0;
      @(negedge clk); act_start = 1'b0;
      while (done !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
      chk(done === 1'b1, "R1", "busy run done", done, 1);
      model(32'h40);
      repeat (60) begin @(negedge clk); if (done === 1'b1) extra++; end
      chk(extra == 0, "R1", "no second done", extra, 0);
      chk(mem32(32'hC8) == 32'hB00, "R1", "ignored descriptor untouched", mem32(32'hC8), 32'hB00);
      cmp_mem("R1", "busy ignore mem");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule